// File: doc/BRIEF.md
# DMA Channel Control and State Unit

This unit holds the control word of a single DMA channel and decides when that channel runs, pauses, finishes or is torn down. Software reaches it through a plain write port and a combinational read port. The control word sits at one address and the event flags at a second address. The datapath side is reduced to plain signals:

- error strobes;
- a block-end strobe with a counters-exhausted qualifier;
- the low link-address bits and the eight link update flags;
- a link-update-done strobe;
- an idle indication.

Software can only start the channel. Hardware is the only agent that stops it: on an error, on completion, or when a deferred abort is finally applied. An abort request is held until the channel is quiescent. That means idle and either stopped, or paused while still running. When the abort is applied, one clear pulse goes to the FIFO and to the channel state.

Three configuration fields are frozen while the channel runs: the step-mode select, the link-fetch port select and the two-bit priority. These fields and the run/pause state are also driven out to the surrounding arbiter and datapath. Six sticky event flags are each gated by their own enable bit. Their OR forms the interrupt request.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Writing the control word (address 0) with bit 0 set and bit 1 clear starts the channel. Writing bit 0 as 0 never stops it. Bit 0 reads back the run state on `chan_en`. After reset the control word reads 0.
- R2: While running, a bus error (`err_bus`) or a setting error (`err_cfg`) stops the channel at that clock edge, with priority over a same-cycle start. The event sets flag bit 2 or flag bit 4 respectively.
- R3: In list mode (bit 9 = 0), a running channel finishes on a `blk_end` that has `blk_cnt_zero` set, `link_addr_lo` equal to 0 and `link_upd_flags` equal to 0. Finishing stops the channel, pulses `done` for exactly one cycle and sets flag bit 0. A `blk_end` without all three conditions leaves the channel running.
- R4: In step mode (bit 9 = 1), the channel finishes on the first `link_upd_done` that follows a `blk_end` seen while running. A `link_upd_done` with no prior block end leaves the channel running.
- R5: Control bit 1 (abort) is write-only and always reads 0. A write with bit 1 set records a pending abort and leaves the run and pause states as they were.
- R6: A pending abort is applied at the first edge where `dp_idle` is high and the channel is either stopped or paused. It then gives one `chan_clr` pulse and clears run and pause. Until that edge it stays pending and `chan_clr` stays low.
- R7: A control write with bit 1 clear loads bit 2 into the pause state (1 pauses, 0 resumes). Bit 2 reads back the pause state on `susp_req`.
- R8: Bit 9 (step mode), bit 10 (link port) and bits 12:11 (priority) are loaded only by a control write made while the channel is stopped. Priority encoding: 00 low/low weight, 01 low/mid weight, 10 low/high weight, 11 high.
- R9: Event flags (address 1, bits 5:0) are sticky. Writing 1 to a flag bit at address 1 clears it, and a same-cycle event wins over the clear.
- R10: Flag bit 5 is set once, in the first cycle in which the channel is running, paused and idle. It is not set again until pause has been released and re-requested.
- R11: `irq` is the OR over the six flags of each flag ANDed with its enable bit, and is registered one cycle behind the flags. The enable bits are control bits 8:3, with bit 3+k enabling flag k.
- R12: While running, `half_evt` sets flag bit 1 and `link_err` sets flag bit 3. All event inputs are ignored while the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| dp_idle | input | 1 | Datapath reports no transfer in flight |
| blk_end | input | 1 | Block transfer finished strobe |
| blk_cnt_zero | input | 1 | Repeat and byte counters both zero |
| link_addr_lo | input | LINK_W | Low bits of the next link address |
| link_upd_flags | input | UPD_N | Link register update flags |
| link_upd_done | input | 1 | Conditional link update finished strobe |
| err_bus | input | 1 | Bus error on a data access |
| err_cfg | input | 1 | Setting error detected |
| link_err | input | 1 | Error during link update |
| half_evt | input | 1 | Half of the block transferred |
| chan_en | output | 1 | Channel running |
| susp_req | output | 1 | Pause requested |
| step_mode | output | 1 | Frozen step-mode select |
| link_port | output | 1 | Frozen link-fetch port select |
| prio | output | 2 | Frozen priority level |
| chan_clr | output | 1 | One-cycle FIFO and state clear pulse |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situation to reach is the deferred abort. It has to be requested while the channel is busy and running, held across several cycles, and then released by a later pause together with idle. The release also coincides with the first pause-idle event, so both effects land on one edge. The directed stimulus builds exactly this order of writes and idle changes. A long random phase then mixes aborts, pauses and completions with free-running idle, and a behavioural model is compared with every output on every clock.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   // event flag indices (also interrupt enable order)
   localparam int EV_TC   = 0;
   localparam int EV_HT   = 1;
   localparam int EV_DTE  = 2;
   localparam int EV_ULE  = 3;
   localparam int EV_USE  = 4;
   localparam int EV_SUSP = 5;
   localparam int EVT_N   = 6;

   // control word layout
   localparam int B_RUN     = 0;
   localparam int B_ABORT   = 1;
   localparam int B_PAUSE   = 2;
   localparam int B_IE_LO   = 3;
   localparam int B_STEP    = B_IE_LO + EVT_N;
   localparam int B_PORT    = B_STEP + 1;
   localparam int B_PRIO_LO = B_PORT + 1;
   localparam int PRIO_W    = 2;
   localparam int CTRL_W    = B_PRIO_LO + PRIO_W;

   typedef enum logic [PRIO_W-1:0] {
      PRIO_LOW_LOW  = 2'b00,
      PRIO_LOW_MID  = 2'b01,
      PRIO_LOW_HIGH = 2'b10,
      PRIO_HIGH     = 2'b11
   } prio_e;

   typedef struct packed {
      logic  step;
      logic  port;
      prio_e prio;
   } lockcfg_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              hw_stop,
   input  logic              rst_fire,
   output logic              en,
   output logic              susp,
   output logic [EVT_N-1:0]  ie,
   output lockcfg_t          cfg
);
   logic plain_wr;
   assign plain_wr = ctrl_wr && !wdata[B_ABORT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         susp <= 1'b0;
         ie   <= '0;
         cfg  <= '0;
      end else begin
         if (rst_fire || hw_stop)
            en <= 1'b0;
         else if (plain_wr && wdata[B_RUN])
            en <= 1'b1;

         if (rst_fire)
            susp <= 1'b0;
         else if (plain_wr)
            susp <= wdata[B_PAUSE];

         if (ctrl_wr)
            ie <= wdata[B_IE_LO +: EVT_N];

         if (ctrl_wr && !en) begin
            cfg.step <= wdata[B_STEP];
            cfg.port <= wdata[B_PORT];
            cfg.prio <= prio_e'(wdata[B_PRIO_LO +: PRIO_W]);
         end
      end
   end

   // R8: frozen fields never move while running
   p_lock_while_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(cfg));

   // R5: an abort write alone does not touch the run state
   p_abort_keeps_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata[B_ABORT] && !rst_fire && !hw_stop) |=> (en == $past(en)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_chan_pkg::*;
#(
   parameter int LINK_W = 16,
   parameter int UPD_N  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              susp,
   input  logic              step,
   input  logic              abort_wr,
   input  logic              dp_idle,
   input  logic              blk_end,
   input  logic              blk_cnt_zero,
   input  logic [LINK_W-1:0] link_lo,
   input  logic [UPD_N-1:0]  upd_flags,
   input  logic              link_upd_done,
   input  logic              err_bus,
   input  logic              err_cfg,
   output logic              complete,
   output logic              hw_stop,
   output logic              rst_fire,
   output logic              susp_evt,
   output logic              chan_clr,
   output logic              done_o
);
   logic pend;
   logic blk_seen;
   logic susp_told;
   logic list_end;

   assign list_end = blk_end && blk_cnt_zero && (link_lo == '0) && (upd_flags == '0);
   assign complete = en && (step ? (link_upd_done && blk_seen) : list_end);
   assign hw_stop  = complete || (en && (err_bus || err_cfg));
   assign rst_fire = pend && dp_idle && (!en || susp);
   assign susp_evt = en && susp && dp_idle && !susp_told;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         blk_seen  <= 1'b0;
         susp_told <= 1'b0;
         chan_clr  <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         if (abort_wr)
            pend <= 1'b1;
         else if (rst_fire)
            pend <= 1'b0;

         if (!en || rst_fire || complete)
            blk_seen <= 1'b0;
         else if (step && blk_end)
            blk_seen <= 1'b1;

         if (!susp)
            susp_told <= 1'b0;
         else if (susp_evt)
            susp_told <= 1'b1;

         chan_clr <= rst_fire;
         done_o   <= complete;
      end
   end

   // R6: the request waits until quiescent
   p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !rst_fire) |=> pend);

   // R6: the clear pulse comes with run and pause dropped
   p_clr_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clr |-> (!en && !susp));

   // R3: completion leaves the channel stopped
   p_done_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !en);

   // R2: errors stop a running channel
   p_err_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (err_bus || err_cfg)) |=> !en);

   // R10: pause-idle event is a single pulse
   p_susp_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      susp_evt |=> !susp_evt);
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
   import dma_chan_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] evt,
   input  logic             clr_wr,
   input  logic [EVT_N-1:0] clr_mask,
   input  logic [EVT_N-1:0] ie,
   output logic [EVT_N-1:0] flags,
   output logic             irq
);
   logic [EVT_N-1:0] clr_eff;
   logic             irq_c;

   assign clr_eff = clr_wr ? clr_mask : '0;
   assign irq_c   = |(flags & ie);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_eff) | evt;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate

   // R9: a flag holds unless its clear bit is written
   for (genvar k = 0; k < EVT_N; k++) begin : g_sticky
      p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && !clr_eff[k]) |=> flags[k]);
   end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_chan_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0,
   parameter int FLAG_ADDR = 1,
   parameter int LINK_W    = 16,
   parameter int UPD_N     = 8,
   parameter bit IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              dp_idle,
   input  logic              blk_end,
   input  logic              blk_cnt_zero,
   input  logic [LINK_W-1:0] link_addr_lo,
   input  logic [UPD_N-1:0]  link_upd_flags,
   input  logic              link_upd_done,
   input  logic              err_bus,
   input  logic              err_cfg,
   input  logic              link_err,
   input  logic              half_evt,
   output logic              chan_en,
   output logic              susp_req,
   output logic              step_mode,
   output logic              link_port,
   output logic [1:0]        prio,
   output logic              chan_clr,
   output logic              done,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);

   initial begin
      assert (DATA_W >= CTRL_W) else $fatal(1, "DATA_W too narrow for the control word");
      assert (CTRL_ADDR != FLAG_ADDR) else $fatal(1, "register addresses collide");
      assert (CTRL_ADDR < (1 << ADDR_W) && FLAG_ADDR < (1 << ADDR_W)) else $fatal(1, "address out of range");
      assert (LINK_W > 0 && UPD_N > 0) else $fatal(1, "link widths must be positive");
   end

   logic             ctrl_wr, flag_wr, abort_wr;
   logic             en, susp;
   logic [EVT_N-1:0] ie, flags, evt;
   lockcfg_t         cfg;
   logic             complete, hw_stop, rst_fire, susp_evt;

   assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
   assign flag_wr  = wr_en && (wr_addr == A_FLAG);
   assign abort_wr = ctrl_wr && wr_data[B_ABORT];

   generate
      if (DATA_W > CTRL_W) begin : g_unused
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];
      end
   endgenerate

   dma_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr),
      .wdata    (wr_data[CTRL_W-1:0]),
      .hw_stop  (hw_stop),
      .rst_fire (rst_fire),
      .en       (en),
      .susp     (susp),
      .ie       (ie),
      .cfg      (cfg)
   );

   dma_chan_seq #(.LINK_W(LINK_W), .UPD_N(UPD_N)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .susp          (susp),
      .step          (cfg.step),
      .abort_wr      (abort_wr),
      .dp_idle       (dp_idle),
      .blk_end       (blk_end),
      .blk_cnt_zero  (blk_cnt_zero),
      .link_lo       (link_addr_lo),
      .upd_flags     (link_upd_flags),
      .link_upd_done (link_upd_done),
      .err_bus       (err_bus),
      .err_cfg       (err_cfg),
      .complete      (complete),
      .hw_stop       (hw_stop),
      .rst_fire      (rst_fire),
      .susp_evt      (susp_evt),
      .chan_clr      (chan_clr),
      .done_o        (done)
   );

   always_comb begin
      evt          = '0;
      evt[EV_TC]   = complete;
      evt[EV_HT]   = en && half_evt;
      evt[EV_DTE]  = en && err_bus;
      evt[EV_ULE]  = en && link_err;
      evt[EV_USE]  = en && err_cfg;
      evt[EV_SUSP] = susp_evt;
   end

   dma_chan_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_wr   (flag_wr),
      .clr_mask (wr_data[EVT_N-1:0]),
      .ie       (ie),
      .flags    (flags),
      .irq      (irq)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[B_RUN]                = en;
         rd_data[B_PAUSE]              = susp;
         rd_data[B_IE_LO +: EVT_N]     = ie;
         rd_data[B_STEP]               = cfg.step;
         rd_data[B_PORT]               = cfg.port;
         rd_data[B_PRIO_LO +: PRIO_W]  = cfg.prio;
      end else if (rd_addr == A_FLAG) begin
         rd_data[EVT_N-1:0] = flags;
      end
   end

   assign chan_en   = en;
   assign susp_req  = susp;
   assign step_mode = cfg.step;
   assign link_port = cfg.port;
   assign prio      = cfg.prio;
endmodule

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic        dp_idle = 1'b0, blk_end = 1'b0, blk_cnt_zero = 1'b0;
   logic [15:0] link_addr_lo = '0;
   logic [7:0]  link_upd_flags = '0;
   logic        link_upd_done = 1'b0, err_bus = 1'b0, err_cfg = 1'b0;
   logic        link_err = 1'b0, half_evt = 1'b0;
   wire  [31:0] rd_data;
   wire         chan_en, susp_req, step_mode, link_port, chan_clr, done, irq;
   wire  [1:0]  prio;

   int tests = 0;
   int fails = 0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   dma_chan_ctrl i_dma_chan_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .dp_idle(dp_idle), .blk_end(blk_end),
      .blk_cnt_zero(blk_cnt_zero), .link_addr_lo(link_addr_lo),
      .link_upd_flags(link_upd_flags), .link_upd_done(link_upd_done),
      .err_bus(err_bus), .err_cfg(err_cfg), .link_err(link_err), .half_evt(half_evt),
      .chan_en(chan_en), .susp_req(susp_req), .step_mode(step_mode),
      .link_port(link_port), .prio(prio), .chan_clr(chan_clr), .done(done), .irq(irq)
   );

   // ---------------- reference model ----------------
   bit       m_en, m_susp, m_pend, m_seen, m_told, m_clr, m_done, m_irq;
   bit [5:0] m_ie, m_flags;
   bit       m_step, m_port;
   bit [1:0] m_prio;

   always @(posedge clk) begin : model
      bit cw, fw, ab, lend, cmp, fire, sevt, stop;
      bit [5:0] ev;
      if (!rst_n) begin
         m_en = 0; m_susp = 0; m_pend = 0; m_seen = 0; m_told = 0;
         m_clr = 0; m_done = 0; m_irq = 0; m_ie = 0; m_flags = 0;
         m_step = 0; m_port = 0; m_prio = 0;
      end else begin
         cw   = wr_en && wr_addr == 4'd0;
         fw   = wr_en && wr_addr == 4'd1;
         ab   = cw && wr_data[1];
         lend = blk_end && blk_cnt_zero && link_addr_lo == 0 && link_upd_flags == 0;
         cmp  = m_en && (m_step ? (link_upd_done && m_seen) : lend);
         fire = m_pend && dp_idle && (!m_en || m_susp);
         sevt = m_en && m_susp && dp_idle && !m_told;
         stop = cmp || (m_en && (err_bus || err_cfg));
         ev   = {sevt, m_en && err_cfg, m_en && link_err, m_en && err_bus, m_en && half_evt, cmp};
         m_irq   = |(m_flags & m_ie);
         m_flags = (m_flags & ~(fw ? wr_data[5:0] : 6'd0)) | ev;
         m_clr   = fire;
         m_done  = cmp;
         if (!m_susp) m_told = 0; else if (sevt) m_told = 1;
         if (!m_en || fire || cmp) m_seen = 0; else if (m_step && blk_end) m_seen = 1;
         if (ab) m_pend = 1; else if (fire) m_pend = 0;
         if (cw && !m_en) begin
            m_step = wr_data[9]; m_port = wr_data[10]; m_prio = wr_data[12:11];
         end
         if (cw) m_ie = wr_data[8:3];
         if (fire) m_susp = 0; else if (cw && !wr_data[1]) m_susp = wr_data[2];
         if (fire || stop) m_en = 0; else if (cw && !wr_data[1] && wr_data[0]) m_en = 1;
      end
   end

   task automatic chk(string tag, string what, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_read(logic [3:0] a);
      logic [31:0] r = '0;
      if (a == 4'd0) r = {19'b0, m_prio, m_port, m_step, m_ie, m_susp, 1'b0, m_en};
      else if (a == 4'd1) r = {26'b0, m_flags};
      return r;
   endfunction

   always @(posedge clk) begin
      #3;
      if (rst_n && cmp_on) begin
         chk("R1", "chan_en", chan_en, m_en);
         chk("R7", "susp_req", susp_req, m_susp);
         chk("R6", "chan_clr", chan_clr, m_clr);
         chk("R3", "done", done, m_done);
         chk("R11", "irq", irq, m_irq);
         chk("R8", "cfg", {step_mode, link_port, prio}, {m_step, m_port, m_prio});
         chk("R9", "rd_data", rd_data, m_read(rd_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] ctl(bit run, bit ab, bit pa, bit [5:0] ie, bit st, bit pt, bit [1:0] pr);
      return {19'b0, pr, pt, st, ie, pa, ab, run};
   endfunction

   task automatic wr(logic [3:0] a, logic [31:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_data = '0;
   endtask

   task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, "read", rd_data, exp);
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      cyc(3);
      // reset state
      chk("R1", "reset chan_en", chan_en, 0);
      chk("R11", "reset irq", irq, 0);
      rst_n = 1;
      cmp_on = 1;
      cyc(1);
      rd_chk("R1", 0, 0);

      // R1/R8: start with priority 11
      wr(0, ctl(1, 0, 0, 6'h3F, 0, 1, 2'b11));
      chk("R1", "start", chan_en, 1);
      chk("R8", "prio loaded", prio, 2'b11);
      wr(0, ctl(1, 0, 0, 6'h3F, 1, 0, 2'b01));
      chk("R8", "prio frozen", prio, 2'b11);
      chk("R8", "port frozen", link_port, 1);
      wr(0, ctl(0, 0, 0, 6'h3F, 0, 0, 2'b00));
      chk("R1", "write 0 ignored", chan_en, 1);

      // R12/R11: half transfer event
      half_evt = 1; cyc(1); half_evt = 0;
      rd_chk("R12", 1, 32'h2);
      cyc(1);
      chk("R11", "irq follows flag", irq, 1);

      // R2: bus error stops
      err_bus = 1; cyc(1); err_bus = 0;
      chk("R2", "bus error stops", chan_en, 0);
      rd_chk("R2", 1, 32'h6);

      // R9: clear
      wr(1, 32'h3F);
      rd_chk("R9", 1, 0);
      cyc(1);
      chk("R11", "irq drops", irq, 0);

      // R12: ignored while stopped
      half_evt = 1; link_err = 1; cyc(1); half_evt = 0; link_err = 0;
      rd_chk("R12", 1, 0);

      // R3: list mode completion
      wr(0, ctl(1, 0, 0, 6'h3F, 0, 0, 2'b10));
      blk_cnt_zero = 1; link_addr_lo = 16'h0040; blk_end = 1; cyc(1); blk_end = 0;
      chk("R3", "non-terminal block", chan_en, 1);
      link_addr_lo = 0; link_upd_flags = 8'h10; blk_end = 1; cyc(1); blk_end = 0;
      chk("R3", "update flag pending", chan_en, 1);
      link_upd_flags = 0; blk_end = 1; cyc(1); blk_end = 0; blk_cnt_zero = 0;
      chk("R3", "terminal stops", chan_en, 0);
      chk("R3", "done pulse", done, 1);
      cyc(1);
      chk("R3", "done one cycle", done, 0);
      wr(1, 32'h3F);

      // R4: step mode
      wr(0, ctl(0, 0, 0, 6'h3F, 1, 0, 2'b00));
      wr(0, ctl(1, 0, 0, 6'h3F, 1, 0, 2'b00));
      chk("R8", "step loaded", step_mode, 1);
      link_upd_done = 1; cyc(1); link_upd_done = 0;
      chk("R4", "update w/o block", chan_en, 1);
      link_addr_lo = 16'h1234; blk_end = 1; cyc(1); blk_end = 0;
      chk("R4", "block alone", chan_en, 1);
      cyc(2);
      link_upd_done = 1; cyc(1); link_upd_done = 0; link_addr_lo = 0;
      chk("R4", "step completes", chan_en, 0);
      chk("R4", "step done", done, 1);
      wr(0, ctl(0, 0, 0, 6'h3F, 0, 0, 2'b00));
      wr(1, 32'h3F);

      // R7/R10: pause and pause-idle event
      dp_idle = 0;
      wr(0, ctl(1, 0, 0, 6'h3F, 0, 0, 2'b00));
      wr(0, ctl(1, 0, 1, 6'h3F, 0, 0, 2'b00));
      chk("R7", "pause set", susp_req, 1);
      rd_chk("R10", 1, 0);
      dp_idle = 1; cyc(1);
      rd_chk("R10", 1, 32'h20);
      wr(1, 32'h20);
      cyc(2);
      rd_chk("R10", 1, 0);
      wr(0, ctl(1, 0, 0, 6'h3F, 0, 0, 2'b00));
      chk("R7", "resume", susp_req, 0);

      // R5/R6: deferred abort while busy
      dp_idle = 0;
      wr(0, ctl(0, 1, 0, 6'h3F, 0, 0, 2'b00));
      rd_chk("R5", 0, ctl(1, 0, 0, 6'h3F, 0, 0, 2'b00));
      chk("R5", "abort keeps run", chan_en, 1);
      cyc(3);
      chk("R6", "pending no clear", chan_clr, 0);
      chk("R6", "still running", chan_en, 1);
      wr(0, ctl(1, 0, 1, 6'h3F, 0, 0, 2'b00));
      dp_idle = 1; cyc(1);
      chk("R6", "clear pulse", chan_clr, 1);
      chk("R6", "run cleared", chan_en, 0);
      chk("R6", "pause cleared", susp_req, 0);
      cyc(1);
      chk("R6", "clear one cycle", chan_clr, 0);

      // R6: abort while stopped and idle
      wr(0, ctl(0, 1, 0, 6'h3F, 0, 0, 2'b00));
      cyc(1);
      chk("R6", "stopped abort", chan_clr, 1);

      // R2: setting error
      wr(1, 32'h3F);
      wr(0, ctl(1, 0, 0, 6'h3F, 0, 0, 2'b00));
      err_cfg = 1; cyc(1); err_cfg = 0;
      chk("R2", "setting error stops", chan_en, 0);
      rd_chk("R2", 1, 32'h10);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         wr_en = ($urandom % 6) == 0;
         wr_addr = 4'($urandom % 3);
         wr_data = $urandom;
         if (($urandom % 4) != 0) wr_data[1] = 1'b0;
         rd_addr = 4'($urandom % 3);
         dp_idle = $urandom % 2;
         blk_end = ($urandom % 5) == 0;
         blk_cnt_zero = $urandom % 2;
         link_addr_lo = (($urandom % 2) == 0) ? 16'h0 : 16'($urandom);
         link_upd_flags = (($urandom % 2) == 0) ? 8'h0 : 8'($urandom);
         link_upd_done = ($urandom % 5) == 0;
         err_bus = ($urandom % 40) == 0;
         err_cfg = ($urandom % 40) == 0;
         link_err = ($urandom % 20) == 0;
         half_evt = ($urandom % 10) == 0;
         @(negedge clk);
      end
      wr_en = 0;
      cyc(2);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule